// File: doc/BRIEF.md
# Security-Filtered Interrupt State Bitmap Bank

This block stores three state bits for every shared interrupt: enable, pending and active. Software reaches them over a 32-bit register bus. Each state has two word addresses. The set address ORs written ones into the state, and the clear address removes written ones. Reading either address returns the same word. Word index n covers interrupts 32n to 32n+31. The first word belongs to the private interrupts and is not stored here.

Every request carries a secure attribute. While the security-disable input is low, a non-secure request only sees and changes the bits of interrupts whose group bit is 1. Each interrupt also has a 2-bit grant field that can widen non-secure access to pending and active state, in graded steps.

The group bits, grant fields, line levels and trigger-mode bits come from neighbouring logic as plain inputs. The pending value read back includes the live line level for level-triggered interrupts. Read data is registered and appears in the cycle after the request.

Top module: `ibk_bank_top`

## Requirements
- R1: A write to a set address (alias code 0 enable, 2 pending, 4 active) sets each state bit whose data bit is 1, within the access mask. Data bits that are 0 leave the state unchanged.
- R2: A write to a clear address (alias code 1 enable, 3 pending, 5 active) clears each state bit whose data bit is 1, within the access mask. Data bits that are 0 leave the state unchanged.
- R3: The following read as zero and ignore writes: word index 0, any word index at or above NUM_IRQ/32, and alias codes 6 and 7. The request address is {alias[2:0], index[IDX_W-1:0]}.
- R4: A secure request, or any request while `sec_off` is 1, reads and writes every implemented bit.
- R5: A non-secure request with `sec_off` 0 reaches enable bits only for interrupts whose group bit is 1. All other enable bits read as zero and ignore writes.
- R6: On the pending set address, a non-secure request with `sec_off` 0 reaches bits where the group bit is 1 or the grant field is 1 or more. This applies to both reads and writes.
- R7: On the pending clear address, a non-secure request with `sec_off` 0 reaches bits where the group bit is 1 or the grant field is 2 or more. This applies to both reads and writes.
- R8: A non-secure request with `sec_off` 0 has these rights on active bits:
  - it reads them through either active address where the group bit is 1 or the grant field is 2 or more;
  - it writes them only where the group bit is 1.
- R9: The pending value read back is the stored pending bit ORed with the input level when the interrupt's trigger bit is 0 (level). When the trigger bit is 1 (edge), the stored bit alone is returned. The access mask is applied after this merge.
- R10: Read data appears on `rsp_rdata` in the cycle after the read request and is zero in every other cycle. A write takes effect at the clock edge that accepts it, so a read in the next cycle sees it.
- R11: Reset clears all enable, pending and active bits.
- R12: For interrupt i (i of 32 or more), the group bit is `irq_group[i-32]`, the trigger bit is `irq_edge[i-32]` and the level is `irq_level[i-32]`. The grant field is `irq_grant[2(i-32)+1 : 2(i-32)]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_secure | input | 1 | Secure attribute of the request |
| req_addr | input | IDX_W+3 | {alias code, word index} |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after a read request |
| sec_off | input | 1 | Security disabled: all requests unrestricted |
| irq_group | input | NUM_IRQ-32 | Group bit per shared interrupt |
| irq_grant | input | 2*(NUM_IRQ-32) | Non-secure grant field per shared interrupt |
| irq_level | input | NUM_IRQ-32 | Live line level per shared interrupt |
| irq_edge | input | NUM_IRQ-32 | Trigger mode per shared interrupt, 1 edge |

## Verification
The assertions assume the group, grant and security-disable inputs are stable during the cycle that carries a request, since the mask is taken from them in that cycle. They also assume at most one request per cycle, with no unknown values on the request lines. The stimulus changes these configuration inputs only between transactions, at the falling clock edge. It keeps each request strobe to a single cycle. The check that a fully locked non-secure write changes nothing relies on the group and grant inputs being all zero in that request cycle.

// File: rtl/ibk_pkg.sv
package ibk_pkg;

    localparam int WORD_W    = 32;
    localparam int PRIV_IRQS = 32;
    localparam int NBANK     = 3;
    localparam int ALIAS_W   = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        AL_EN_SET = 3'd0,
        AL_EN_CLR = 3'd1,
        AL_PD_SET = 3'd2,
        AL_PD_CLR = 3'd3,
        AL_AC_SET = 3'd4,
        AL_AC_CLR = 3'd5,
        AL_RSV6   = 3'd6,
        AL_RSV7   = 3'd7
    } alias_e;

    typedef enum logic [1:0] {
        BK_ENABLE = 2'd0,
        BK_PEND   = 2'd1,
        BK_ACTIVE = 2'd2,
        BK_NONE   = 2'd3
    } bank_e;

    typedef struct packed {
        logic  rd;
        logic  wr;
        logic  secure;
        bank_e bank;
        logic  clr;
        logic  hit;
    } acc_t;

    typedef struct packed {
        word_t wmask;
        word_t rmask;
    } mask_t;

    function automatic bank_e alias_bank(input alias_e a);
        case (a)
            AL_EN_SET, AL_EN_CLR: return BK_ENABLE;
            AL_PD_SET, AL_PD_CLR: return BK_PEND;
            AL_AC_SET, AL_AC_CLR: return BK_ACTIVE;
            default:              return BK_NONE;
        endcase
    endfunction

    function automatic logic alias_is_clear(input alias_e a);
        case (a)
            AL_EN_CLR, AL_PD_CLR, AL_AC_CLR: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

    // grant level of at least one: either bit of the field
    function automatic logic grant_ge1(input logic [1:0] f);
        return f[1] | f[0];
    endfunction

    // grant level of at least two: upper bit only
    function automatic logic grant_ge2(input logic [1:0] f);
        return f[1];
    endfunction

endpackage

// File: rtl/ibk_decode.sv
module ibk_decode
    import ibk_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int NWORDS = 3
) (
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     req_secure,
    input  logic [IDX_W+ALIAS_W-1:0] req_addr,
    output acc_t                     acc,
    output logic [IDX_W-1:0]         idx
);

    localparam logic [IDX_W:0] NW = (IDX_W+1)'(NWORDS);

    alias_e al;

    assign al  = alias_e'(req_addr[IDX_W +: ALIAS_W]);
    assign idx = req_addr[IDX_W-1:0];

    always_comb begin
        acc.rd     = req_valid & ~req_write;
        acc.wr     = req_valid & req_write;
        acc.secure = req_secure;
        acc.bank   = alias_bank(al);
        acc.clr    = alias_is_clear(al);
        acc.hit    = (idx != '0) && ({1'b0, idx} < NW) && (acc.bank != BK_NONE);
    end

endmodule

// File: rtl/ibk_mask.sv
module ibk_mask
    import ibk_pkg::*;
#(
    parameter int NSPI  = 64,
    parameter int IDX_W = 5
) (
    input  logic              secure,
    input  logic              sec_off,
    input  bank_e             bank,
    input  logic              clr,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [NSPI-1:0]   grp,
    input  logic [2*NSPI-1:0] grant,
    output mask_t             mask
);

    localparam int NSW = NSPI / WORD_W;

    logic [NSW-1:0][WORD_W-1:0] g_w, e1_w, e2_w;
    word_t g_s, e1_s, e2_s;
    word_t wm, rm;
    logic  open_acc;

    for (genvar w = 0; w < NSW; w++) begin : g_word
        for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            assign g_w[w][b]  = grp[w*WORD_W + b];
            assign e1_w[w][b] = grant_ge1(grant[2*(w*WORD_W + b) +: 2]);
            assign e2_w[w][b] = grant_ge2(grant[2*(w*WORD_W + b) +: 2]);
        end
    end

    // pick the addressed shared word (word index 1 is the first shared word)
    always_comb begin
        g_s  = '0;
        e1_s = '0;
        e2_s = '0;
        for (int w = 0; w < NSW; w++) begin
            if ({1'b0, idx} == (IDX_W+1)'(w + 1)) begin
                g_s  = g_w[w];
                e1_s = e1_w[w];
                e2_s = e2_w[w];
            end
        end
    end

    always_comb begin
        open_acc = secure | sec_off;
        case (bank)
            BK_ENABLE: begin
                wm = g_s;
                rm = g_s;
            end
            BK_PEND: begin
                wm = clr ? (g_s | e2_s) : (g_s | e1_s);
                rm = wm;
            end
            BK_ACTIVE: begin
                wm = g_s;
                rm = g_s | e2_s;
            end
            default: begin
                wm = '0;
                rm = '0;
            end
        endcase
        if (open_acc && bank != BK_NONE) begin
            wm = '1;
            rm = '1;
        end
        if (!hit) begin
            wm = '0;
            rm = '0;
        end
        mask.wmask = wm;
        mask.rmask = rm;
    end

endmodule

// File: rtl/ibk_bank.sv
module ibk_bank
    import ibk_pkg::*;
#(
    parameter int NSPI  = 64,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             clr,
    input  logic [IDX_W-1:0] idx,
    input  word_t            bits,
    output logic [NSPI-1:0]  state_q
);

    localparam int NSW = NSPI / WORD_W;

    logic [NSW-1:0][WORD_W-1:0] word_q;

    for (genvar w = 0; w < NSW; w++) begin : g_word
        logic sel;
        assign sel = wr_en && ({1'b0, idx} == (IDX_W+1)'(w + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[w] <= '0;
            end else if (sel) begin
                if (clr) begin
                    word_q[w] <= word_q[w] & ~bits;
                end else begin
                    word_q[w] <= word_q[w] | bits;
                end
            end
        end
    end

    assign state_q = word_q;

endmodule

// File: rtl/ibk_rdmux.sv
module ibk_rdmux
    import ibk_pkg::*;
#(
    parameter int NSPI  = 64,
    parameter int IDX_W = 5
) (
    input  bank_e                       bank,
    input  logic                        hit,
    input  logic [IDX_W-1:0]            idx,
    input  logic [NBANK-1:0][NSPI-1:0]  bank_q,
    input  logic [NSPI-1:0]             level,
    input  logic [NSPI-1:0]             edge_mode,
    input  word_t                       rmask,
    output word_t                       rword
);

    localparam int NSW = NSPI / WORD_W;

    logic [NSPI-1:0] pend_view;
    logic [NSPI-1:0] view;
    word_t           sel;

    // level-triggered lines show their live level on top of the latch
    assign pend_view = bank_q[int'(BK_PEND)] | (level & ~edge_mode);

    always_comb begin
        case (bank)
            BK_ENABLE: view = bank_q[int'(BK_ENABLE)];
            BK_PEND:   view = pend_view;
            BK_ACTIVE: view = bank_q[int'(BK_ACTIVE)];
            default:   view = '0;
        endcase
    end

    always_comb begin
        sel = '0;
        for (int w = 0; w < NSW; w++) begin
            if ({1'b0, idx} == (IDX_W+1)'(w + 1)) begin
                sel = view[w*WORD_W +: WORD_W];
            end
        end
    end

    assign rword = hit ? (sel & rmask) : '0;

endmodule

// File: rtl/ibk_bank_top.sv
module ibk_bank_top
    import ibk_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int IDX_W   = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic                              req_secure,
    input  logic [IDX_W+ALIAS_W-1:0]          req_addr,
    input  logic [WORD_W-1:0]                 req_wdata,
    output logic [WORD_W-1:0]                 rsp_rdata,
    input  logic                              sec_off,
    input  logic [NUM_IRQ-PRIV_IRQS-1:0]      irq_group,
    input  logic [2*(NUM_IRQ-PRIV_IRQS)-1:0]  irq_grant,
    input  logic [NUM_IRQ-PRIV_IRQS-1:0]      irq_level,
    input  logic [NUM_IRQ-PRIV_IRQS-1:0]      irq_edge
);

    localparam int NSPI   = NUM_IRQ - PRIV_IRQS;
    localparam int NWORDS = NUM_IRQ / WORD_W;

    acc_t                       acc;
    logic [IDX_W-1:0]           idx;
    mask_t                      mask;
    word_t                      wbits;
    word_t                      rword;
    word_t                      rsp_q;
    logic [NBANK-1:0][NSPI-1:0] bank_q;

    ibk_decode #(.IDX_W(IDX_W), .NWORDS(NWORDS)) u_decode (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_secure (req_secure),
        .req_addr   (req_addr),
        .acc        (acc),
        .idx        (idx)
    );

    ibk_mask #(.NSPI(NSPI), .IDX_W(IDX_W)) u_mask (
        .secure  (acc.secure),
        .sec_off (sec_off),
        .bank    (acc.bank),
        .clr     (acc.clr),
        .hit     (acc.hit),
        .idx     (idx),
        .grp     (irq_group),
        .grant   (irq_grant),
        .mask    (mask)
    );

    assign wbits = req_wdata & mask.wmask;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = acc.wr && acc.hit && (acc.bank == bank_e'(2'(b)));

        ibk_bank #(.NSPI(NSPI), .IDX_W(IDX_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bank_wr),
            .clr     (acc.clr),
            .idx     (idx),
            .bits    (wbits),
            .state_q (bank_q[b])
        );
    end

    ibk_rdmux #(.NSPI(NSPI), .IDX_W(IDX_W)) u_rdmux (
        .bank      (acc.bank),
        .hit       (acc.hit),
        .idx       (idx),
        .bank_q    (bank_q),
        .level     (irq_level),
        .edge_mode (irq_edge),
        .rmask     (mask.rmask),
        .rword     (rword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= acc.rd ? rword : '0;
        end
    end

    assign rsp_rdata = rsp_q;

endmodule

// File: rtl/ibk_checker.sv
module ibk_checker
    import ibk_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int IDX_W   = 5
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 req_valid,
    input logic                                 req_write,
    input logic                                 req_secure,
    input logic [IDX_W+ALIAS_W-1:0]             req_addr,
    input logic [WORD_W-1:0]                    req_wdata,
    input logic [WORD_W-1:0]                    rsp_rdata,
    input logic                                 sec_off,
    input logic [NUM_IRQ-PRIV_IRQS-1:0]         irq_group,
    input logic [2*(NUM_IRQ-PRIV_IRQS)-1:0]     irq_grant,
    input logic [NBANK-1:0][NUM_IRQ-PRIV_IRQS-1:0] bank_q
);

    localparam logic [IDX_W:0] NW = (IDX_W+1)'(NUM_IRQ / WORD_W);

    logic [IDX_W-1:0]   c_idx;
    logic [ALIAS_W-1:0] c_alias;
    logic               c_rd, c_wr;

    assign c_idx   = req_addr[IDX_W-1:0];
    assign c_alias = req_addr[IDX_W +: ALIAS_W];
    assign c_rd    = req_valid && !req_write;
    assign c_wr    = req_valid && req_write;

    // R1 / R2: all-zero write data leaves every state bit alone
    a_r1_zero_data_keeps: assert property (@(posedge clk) disable iff (rst)
        (c_wr && req_wdata == '0) |=> $stable(bank_q));

    // R2: a clear-address write never raises a bit
    a_r2_clear_never_sets: assert property (@(posedge clk) disable iff (rst)
        (c_wr && c_alias < 3'd6 && c_alias[0]) |=> ((bank_q & ~$past(bank_q)) == '0));

    // R3: reserved alias codes read zero
    a_r3_reserved_alias_zero: assert property (@(posedge clk) disable iff (rst)
        (c_rd && c_alias >= 3'd6) |=> (rsp_rdata == '0));

    // R3: private word and out-of-range words read zero
    a_r3_unmapped_word_zero: assert property (@(posedge clk) disable iff (rst)
        (c_rd && (c_idx == '0 || {1'b0, c_idx} >= NW)) |=> (rsp_rdata == '0));

    // R3: writes to private or out-of-range words or reserved aliases change nothing
    a_r3_unmapped_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (c_wr && (c_idx == '0 || {1'b0, c_idx} >= NW || c_alias >= 3'd6)) |=> $stable(bank_q));

    // R5: a non-secure write with no group bits and no grants changes nothing
    a_r5_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (c_wr && !req_secure && !sec_off && irq_group == '0 && irq_grant == '0)
        |=> $stable(bank_q));

    // R5: the same locked non-secure read returns zero
    a_r5_locked_read_zero: assert property (@(posedge clk) disable iff (rst)
        (c_rd && !req_secure && !sec_off && irq_group == '0 && irq_grant == '0)
        |=> (rsp_rdata == '0));

    // R10: no read request, no read data
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!c_rd) |=> (rsp_rdata == '0));

endmodule

bind ibk_bank_top ibk_checker #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .sec_off    (sec_off),
    .irq_group  (irq_group),
    .irq_grant  (irq_grant),
    .bank_q     (bank_q)
);

// File: tb/tb_ibk_bank_top.sv
module tb_ibk_bank_top;

    localparam int NUM_IRQ = 96;
    localparam int IDX_W   = 5;
    localparam int NSPI    = NUM_IRQ - 32;

    localparam logic [2:0] EN_S = 3'd0, EN_C = 3'd1, PD_S = 3'd2, PD_C = 3'd3,
                           AC_S = 3'd4, AC_C = 3'd5, RSV6 = 3'd6;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic                    req_write = 1'b0;
    logic                    req_secure = 1'b0;
    logic [IDX_W+2:0]        req_addr = '0;
    logic [31:0]             req_wdata = '0;
    logic [31:0]             rsp_rdata;
    logic                    sec_off = 1'b0;
    logic [NSPI-1:0]         irq_group = '0;
    logic [2*NSPI-1:0]       irq_grant = '0;
    logic [NSPI-1:0]         irq_level = '0;
    logic [NSPI-1:0]         irq_edge = '1;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ibk_bank_top #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_secure (req_secure),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_rdata  (rsp_rdata),
        .sec_off    (sec_off),
        .irq_group  (irq_group),
        .irq_grant  (irq_grant),
        .irq_level  (irq_level),
        .irq_edge   (irq_edge)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] al, input int ix, input logic [31:0] d, input logic sec);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = 1'b1;
        req_secure = sec;
        req_addr   = {al, IDX_W'(ix)};
        req_wdata  = d;
        @(negedge clk);
        req_valid  = 1'b0;
        req_write  = 1'b0;
        req_wdata  = '0;
    endtask

    task automatic rd(input logic [2:0] al, input int ix, input logic sec, output logic [31:0] d);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = 1'b0;
        req_secure = sec;
        req_addr   = {al, IDX_W'(ix)};
        @(negedge clk);
        req_valid  = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] al, input int ix,
                          input logic sec, input logic [31:0] exp);
        logic [31:0] d;
        rd(al, ix, sec, d);
        check(tag, d, exp);
    endtask

    // grant field for shared index j lives at bits [2j+1:2j]
    task automatic set_grant(input int j, input logic [1:0] f);
        irq_grant[2*j +: 2] = f;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 idle after reset", rsp_rdata, 32'h0);
        for (int ix = 1; ix < 3; ix++) begin
            rd_chk("R11 enable reset", EN_S, ix, 1'b1, 32'h0);
            rd_chk("R11 pending reset", PD_S, ix, 1'b1, 32'h0);
            rd_chk("R11 active reset", AC_C, ix, 1'b1, 32'h0);
        end
    endtask

    task automatic t_set;
        wr(EN_S, 1, 32'h0000_00F0, 1'b1);
        rd_chk("R1 set basic", EN_S, 1, 1'b1, 32'h0000_00F0);
        wr(EN_S, 1, 32'h0, 1'b1);
        rd_chk("R1 zero write no effect", EN_S, 1, 1'b1, 32'h0000_00F0);
        wr(EN_S, 1, 32'h0F00_0001, 1'b1);
        rd_chk("R1 set accumulates via clear alias read", EN_C, 1, 1'b1, 32'h0F00_00F1);
    endtask

    task automatic t_clear;
        wr(EN_C, 1, 32'h0000_0030, 1'b1);
        rd_chk("R2 clear basic", EN_S, 1, 1'b1, 32'h0F00_00C1);
        wr(EN_C, 1, 32'h0, 1'b1);
        rd_chk("R2 zero clear no effect", EN_S, 1, 1'b1, 32'h0F00_00C1);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(EN_S, 0, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R3 private word reads zero", EN_S, 0, 1'b1, 32'h0);
        wr(PD_S, 3, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R3 out-of-range word", PD_S, 3, 1'b1, 32'h0);
        wr(RSV6, 1, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R3 reserved alias", RSV6, 1, 1'b1, 32'h0);
        rd_chk("R3 word1 untouched", EN_S, 1, 1'b1, 32'h0F00_00C1);
        rd_chk("R3 word2 pending untouched", PD_S, 2, 1'b1, 32'h0);
        rd(EN_S, 1, 1'b1, d);
        @(negedge clk);
        check("R10 data only for one cycle", rsp_rdata, 32'h0);
    endtask

    task automatic t_secoff;
        sec_off = 1'b1;
        wr(EN_S, 2, 32'hFFFF_0000, 1'b0);
        rd_chk("R4 non-secure with security off", EN_S, 2, 1'b0, 32'hFFFF_0000);
        sec_off = 1'b0;
        rd_chk("R5 non-secure no group sees zero", EN_S, 2, 1'b0, 32'h0);
    endtask

    task automatic t_group;
        irq_group[63:32] = 32'h00FF_FF00;
        rd_chk("R5 group-filtered read", EN_S, 2, 1'b0, 32'h00FF_0000);
        wr(EN_C, 2, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R5 group-filtered clear", EN_S, 2, 1'b1, 32'hFF00_0000);
        wr(EN_S, 2, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R5 group-filtered set", EN_S, 2, 1'b1, 32'hFFFF_FF00);
    endtask

    task automatic t_pending_grant;
        irq_group[31:0] = '0;
        for (int j = 0; j < 32; j++) begin
            set_grant(j, (j < 8) ? 2'd1 : (j < 16) ? 2'd2 : (j < 24) ? 2'd3 : 2'd0);
        end
        wr(PD_S, 1, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R6 ns set limited by grant>=1", PD_S, 1, 1'b1, 32'h00FF_FFFF);
        rd_chk("R6 ns read set alias", PD_S, 1, 1'b0, 32'h00FF_FFFF);
        rd_chk("R7 ns read clear alias", PD_C, 1, 1'b0, 32'h00FF_FF00);
        wr(PD_C, 1, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R7 ns clear limited by grant>=2", PD_S, 1, 1'b1, 32'h0000_00FF);
        wr(PD_S, 1, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R6 field zero hidden", PD_S, 1, 1'b0, 32'h00FF_FFFF);
    endtask

    task automatic t_active;
        wr(AC_S, 1, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R8 ns read active set alias", AC_S, 1, 1'b0, 32'h00FF_FF00);
        rd_chk("R8 ns read active clear alias", AC_C, 1, 1'b0, 32'h00FF_FF00);
        wr(AC_C, 1, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R8 ns active write needs group", AC_S, 1, 1'b1, 32'hFFFF_FFFF);
        irq_group[31:0] = 32'h0000_0001;
        wr(AC_C, 1, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R8 ns active clear group bit", AC_S, 1, 1'b1, 32'hFFFF_FFFE);
        rd_chk("R8 ns active read group|grant", AC_S, 1, 1'b0, 32'h00FF_FF00);
    endtask

    task automatic t_level;
        wr(PD_C, 1, 32'hFFFF_FFFF, 1'b1);
        irq_edge[31:0]  = 32'hFFFF_0000;
        irq_level[31:0] = 32'h00FF_00FF;
        rd_chk("R9 level lines merge, edge lines do not", PD_S, 1, 1'b1, 32'h0000_00FF);
        wr(PD_S, 1, 32'h0000_0F00, 1'b1);
        rd_chk("R9 latch or level", PD_S, 1, 1'b1, 32'h0000_0FFF);
        irq_edge[31:0]  = 32'h0;
        irq_level[31:0] = 32'hFF00_0000;
        rd_chk("R9 secure merged view", PD_C, 1, 1'b1, 32'hFF00_0F00);
        rd_chk("R9 mask after merge", PD_S, 1, 1'b0, 32'h0000_0F00);
        irq_level = '0;
        irq_edge  = '1;
    endtask

    task automatic t_fieldpos;
        irq_group[63:32] = '0;
        for (int j = 32; j < 64; j++) set_grant(j, 2'd0);
        set_grant(32, 2'd1);
        set_grant(33, 2'd2);
        wr(PD_S, 2, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R12 grant fields of irq 64/65", PD_S, 2, 1'b1, 32'h0000_0003);
        wr(PD_C, 2, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R12 only irq 65 clearable", PD_S, 2, 1'b1, 32'h0000_0001);
        rd_chk("R4 secure read word1 pending", PD_S, 1, 1'b1, 32'h0000_0F00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set();
        t_clear();
        t_unmapped();
        t_secoff();
        t_group();
        t_pending_grant();
        t_active();
        t_level();
        t_fieldpos();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule